// File: doc/BRIEF.md
# Serial Packet Receiver with Packet Memory

This block takes a serial bit stream that runs at one quarter of the system clock rate and stores one fixed-length packet in an internal memory of 64 words of 4 bits. It samples each serial bit once within its four-cycle period and collects four bits into a word. Each full word goes to the next memory address through active-low select and write strobes. When the last word has been written, the block raises a ready flag and gives the memory to a downstream consumer. The consumer reads the memory through an address input and a data output.

The consumer ends its turn by pulsing a processed acknowledge. The memory then returns to the receiver, and reception of the next packet starts at address 0. The serial stream carries information bits as two-bit codewords: a 1 is sent as a 1 followed by a 0, and a 0 as a 0 followed by a 1. Any other pair sets a sticky error flag, which is cleared only when the next packet starts.

Top module: `serial_pkt_rx`

## Requirements
- R1: After reset, `pkt_ready`, `code_err` and `rd_data` are 0, `ram_cs_n` and `ram_we_n` are 1, and the first word received is stored at address 0.
- R2: Bit period timing is counted from the first clock edge after reset release, or from the edge that accepts an acknowledge. Each bit period is four clock edges long. The line is sampled once per period, at the third edge, so a bit held for four cycles is captured exactly once.
- R3: Word i of a packet holds serial bits 4i to 4i+3, with the earliest bit in word bit 0. The write address increases by one after each word.
- R4: Each word is written by one cycle in which `ram_cs_n` and `ram_we_n` are both 0. A packet produces exactly 64 such cycles, and `ram_we_n` is never 0 while `ram_cs_n` is 1.
- R5: `pkt_ready` rises right after the edge that samples serial bit 255 (the third edge of that bit period), and it then stays high until an acknowledge is accepted.
- R6: While `pkt_ready` is high, `rd_data` combinationally shows the word at `rd_addr`, `ram_cs_n` is 0 and `ram_we_n` is 1. While `pkt_ready` is low, `rd_data` is 0.
- R7: While `pkt_ready` is high, activity on `ser_in` changes no stored word.
- R8: `proc_ack` high at a clock edge while `pkt_ready` is high drops `pkt_ready` after that edge and starts a new packet at address 0. `proc_ack` during reception has no effect.
- R9: Serial bits 2j and 2j+1 form codeword j. The values 1,0 and 0,1 are valid. The values 0,0 and 1,1 set `code_err`, which holds through the ready period and clears on the edge that accepts the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four cycles per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data, earliest bit first |
| proc_ack | input | 1 | Consumer finished with the stored packet |
| rd_addr | input | 6 | Consumer read address |
| pkt_ready | output | 1 | Packet complete, memory owned by consumer |
| rd_data | output | 4 | Word at `rd_addr` while ready, else 0 |
| code_err | output | 1 | Sticky invalid-codeword flag for the current packet |
| ram_cs_n | output | 1 | Active-low memory select |
| ram_we_n | output | 1 | Active-low memory write enable |

## Verification
The bench sends packets built from info patterns of all ones, all zeros and several seeded random words. The all-ones and all-zeros packets give opposite constant codewords, which exposes a bit-order swap inside words and pairs. The random packets catch address skips and stale words. Two directed packets carry an illegal pair, 1,1 in the last position and 0,0 in the first, to test both flag polarity and the clearing on acknowledge. Random line activity during the ready period and an acknowledge pulse in the middle of reception check that those inputs cannot disturb the stored packet.

// File: rtl/sprx_pkg.sv
package sprx_pkg;
   typedef enum logic {
      ST_FILL = 1'b0,
      ST_HOLD = 1'b1
   } sprx_state_e;
endpackage

// File: rtl/sprx_bit_timer.sv
module sprx_bit_timer #(
   parameter int OVERSAMPLE = 4,
   parameter int SAMPLE_AT  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic strobe
);
   localparam int  PH_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
   localparam bit  POW2 = (OVERSAMPLE == (1 << PH_W));

   logic [PH_W-1:0] phase;
   logic [PH_W-1:0] phase_nx;

   generate
      if (OVERSAMPLE < 2 || SAMPLE_AT < 0 || SAMPLE_AT >= OVERSAMPLE) begin : g_bad_cfg
         $error("sprx_bit_timer: sample phase must lie inside a period of at least two cycles");
      end
      if (POW2) begin : g_wrap
         assign phase_nx = phase + PH_W'(1);
      end else begin : g_cmp
         assign phase_nx = (phase == PH_W'(OVERSAMPLE - 1)) ? '0 : phase + PH_W'(1);
      end
   endgenerate

   assign strobe = run && (phase == PH_W'(SAMPLE_AT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase <= '0;
      else if (restart) phase <= '0;
      else if (run)     phase <= phase_nx;
   end

   // one sample per bit period
   assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
endmodule

// File: rtl/sprx_packer.sv
module sprx_packer #(
   parameter int WORD_W = 4,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              strobe,
   input  logic              bit_in,
   output logic              wr_fire,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_word,
   output logic              last_bit,
   output logic              code_bad
);
   localparam int SUB_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam int CNT_W = ADDR_W + SUB_W;

   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] shreg;
   logic              pair_bad;

   generate
      if (WORD_W < 2 || WORD_W != (1 << SUB_W)) begin : g_bad_cfg
         $error("sprx_packer: word width must be a power of two so codewords never straddle words");
      end
   endgenerate

   assign wr_addr  = cnt[CNT_W-1:SUB_W];
   assign wr_word  = {bit_in, shreg[WORD_W-1:1]};
   assign wr_fire  = strobe && (cnt[SUB_W-1:0] == {SUB_W{1'b1}});
   assign last_bit = strobe && (cnt == {CNT_W{1'b1}});
   assign pair_bad = strobe && cnt[0] && (bit_in == shreg[WORD_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         shreg    <= '0;
         code_bad <= 1'b0;
      end else if (restart) begin
         cnt      <= '0;
         code_bad <= 1'b0;
      end else if (strobe) begin
         cnt   <= cnt + CNT_W'(1);
         shreg <= wr_word;
         if (pair_bad) code_bad <= 1'b1;
      end
   end

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !last_bit && !restart) |=> (wr_addr == ADDR_W'($past(wr_addr) + ADDR_W'(1))));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (code_bad && !restart) |=> code_bad);
endmodule

// File: rtl/sprx_word_store.sv
module sprx_word_store #(
   parameter int WORD_W = 4,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!cs_n && !we_n) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/serial_pkt_rx.sv
module serial_pkt_rx
   import sprx_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int WORD_W     = 4,
   parameter int OVERSAMPLE = 4,
   parameter int SAMPLE_AT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_in,
   input  logic              proc_ack,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              pkt_ready,
   output logic [WORD_W-1:0] rd_data,
   output logic              code_err,
   output logic              ram_cs_n,
   output logic              ram_we_n
);
   sprx_state_e       state;
   logic              hold;
   logic              restart;
   logic              strobe;
   logic              wr_fire;
   logic              last_bit;
   logic [ADDR_W-1:0] wr_addr;
   logic [ADDR_W-1:0] ram_addr;
   logic [WORD_W-1:0] wr_word;
   logic [WORD_W-1:0] ram_q;

   assign hold    = (state == ST_HOLD);
   assign restart = hold && proc_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FILL;
      else begin
         case (state)
            ST_FILL: if (last_bit) state <= ST_HOLD;
            ST_HOLD: if (proc_ack) state <= ST_FILL;
            default: state <= ST_FILL;
         endcase
      end
   end

   sprx_bit_timer #(.OVERSAMPLE(OVERSAMPLE), .SAMPLE_AT(SAMPLE_AT)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(!hold), .restart(restart), .strobe(strobe)
   );

   sprx_packer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_packer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .strobe(strobe), .bit_in(ser_in),
      .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_word(wr_word),
      .last_bit(last_bit), .code_bad(code_err)
   );

   assign ram_addr = hold ? rd_addr : wr_addr;
   assign ram_cs_n = !(wr_fire || hold);
   assign ram_we_n = !wr_fire;

   sprx_word_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
      .clk(clk), .cs_n(ram_cs_n), .we_n(ram_we_n), .addr(ram_addr),
      .wdata(wr_word), .rdata(ram_q)
   );

   assign pkt_ready = hold;
   assign rd_data   = hold ? ram_q : '0;

   assert_ready_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_ready && !proc_ack) |=> pkt_ready);

   assert_ready_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_ready) |-> $past(!ram_we_n));

   assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_ready && proc_ack) |=> !pkt_ready);

   assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(code_err) |-> $past(pkt_ready && proc_ack));

   assert_no_write_when_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ready |-> (ram_we_n && !ram_cs_n));
endmodule

// File: tb/serial_pkt_rx_tb.sv
`timescale 1ns/100ps
module serial_pkt_rx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_in = 1'b0;
   logic       proc_ack = 1'b0;
   logic [5:0] rd_addr = '0;
   logic       pkt_ready;
   logic [3:0] rd_data;
   logic       code_err;
   logic       ram_cs_n;
   logic       ram_we_n;

   int total = 0;
   int bad = 0;
   int wr_cnt = 0;
   int strobe_bad = 0;

   always #2.5 clk = ~clk;

   serial_pkt_rx u_dut (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .proc_ack(proc_ack),
      .rd_addr(rd_addr), .pkt_ready(pkt_ready), .rd_data(rd_data),
      .code_err(code_err), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n)
   );

   always @(negedge clk) begin
      if (!ram_we_n) wr_cnt++;
      if (!ram_we_n && ram_cs_n) strobe_bad++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [255:0] encode(input logic [127:0] info);
      logic [255:0] r;
      for (int i = 0; i < 128; i++) begin
         r[2*i]   = info[i];
         r[2*i+1] = ~info[i];
      end
      return r;
   endfunction

   function automatic bit exp_err(input logic [255:0] r);
      for (int j = 0; j < 128; j++) if (r[2*j] == r[2*j+1]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [127:0] rnd_info();
      logic [127:0] v;
      for (int i = 0; i < 4; i++) v[32*i +: 32] = $urandom;
      return v;
   endfunction

   // drives one packet; optional acknowledge pulse mid-packet (must be ignored, R8)
   task automatic send_pkt(input logic [255:0] r, input bit ack_noise);
      wr_cnt = 0;
      for (int k = 0; k < 256; k++) begin
         ser_in = r[k];
         proc_ack = (ack_noise && k == 100);
         for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            if (k == 128 && j == 0)
               check(!pkt_ready && rd_data == 4'd0, "R6 idle read", rd_data, 0);
            if (k == 255 && j == 1)
               check(!pkt_ready, "R5 early ready", pkt_ready, 0);
            if (k == 255 && j == 2)
               check(pkt_ready, "R5 ready after last sample", pkt_ready, 1);
            if (k == 101 && j == 0 && ack_noise)
               check(!pkt_ready, "R8 ack during reception", pkt_ready, 0);
         end
      end
      proc_ack = 1'b0;
      check(wr_cnt == 64, "R4 writes per packet", wr_cnt, 64);
      check(strobe_bad == 0, "R4 write without select", strobe_bad, 0);
   endtask

   task automatic verify(input logic [255:0] r, input string tag);
      int errs = 0;
      check(!ram_cs_n && ram_we_n, "R6 strobes while ready", {ram_cs_n, ram_we_n}, 2'b01);
      for (int i = 0; i < 64; i++) begin
         rd_addr = 6'(i);
         #0.05;
         if (rd_data !== r[4*i +: 4]) begin
            errs++;
            check(1'b0, {"R3 word ", tag}, rd_data, r[4*i +: 4]);
         end
      end
      if (errs == 0) check(1'b1, "R3", 0, 0);
      check(code_err == exp_err(r), {"R9 error flag ", tag}, code_err, exp_err(r));
   endtask

   task automatic release_pkt();
      proc_ack = 1'b1;
      @(negedge clk);
      proc_ack = 1'b0;
      check(!pkt_ready && rd_data == 4'd0, "R8 ready drops after ack", pkt_ready, 0);
      check(!code_err, "R9 error cleared at new packet", code_err, 0);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [255:0] p;
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      check(!pkt_ready && !code_err && rd_data == 4'd0, "R1 reset outputs", pkt_ready, 0);
      check(ram_cs_n && ram_we_n, "R1 reset strobes", {ram_cs_n, ram_we_n}, 2'b11);
      rst_n = 1'b1;

      // all ones, with ignored ack (R2, R3, R8); first word lands at address 0 (R1)
      p = encode({128{1'b1}});
      send_pkt(p, 1'b1);
      verify(p, "ones");

      // line noise while ready (R7)
      for (int c = 0; c < 200; c++) begin
         ser_in = 1'($urandom);
         @(negedge clk);
      end
      check(pkt_ready, "R5 ready held without ack", pkt_ready, 1);
      verify(p, "R7 after noise");
      release_pkt();

      p = encode({128{1'b0}});
      send_pkt(p, 1'b0);
      verify(p, "zeros");
      release_pkt();

      for (int n = 0; n < 3; n++) begin
         p = encode(rnd_info());
         send_pkt(p, 1'b0);
         verify(p, "random");
         release_pkt();
      end

      // illegal 1,1 in the last pair
      p = encode(rnd_info());
      p[255:254] = 2'b11;
      send_pkt(p, 1'b0);
      verify(p, "bad last");
      check(code_err, "R9 flag for 11", code_err, 1);
      release_pkt();

      // illegal 0,0 in the first pair
      p = encode(rnd_info());
      p[1:0] = 2'b00;
      send_pkt(p, 1'b0);
      verify(p, "bad first");
      check(code_err, "R9 flag for 00", code_err, 1);
      release_pkt();

      p = encode(rnd_info());
      send_pkt(p, 1'b0);
      verify(p, "clean after error");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule